// File: doc/BRIEF.md
# Tiled View Address Generator

This block maps a pixel position inside a two-dimensional tiled container to the 32-bit address through which that pixel is reached in a chosen view. A view is a combination of mirroring in x, mirroring in y and a 90-degree transposition. The pixel formats are 8-bit, 16-bit and 32-bit tiled, plus a page-granular mode. Each format drops a fixed number of low coordinate bits, so each format has its own usable x and y range.

Besides the address, the block returns three values for the format and view: a line stride, which is the address distance between vertically adjacent pixels of the view, and the width and height of one slot in pixels. A request enters on a valid/ready input channel, and its result leaves one cycle later on a valid/ready output channel.

The block has a single result register. It accepts a new request whenever that register is empty or is being drained in the same cycle. While the output is valid and `res_ready` is low, the result stays frozen and `req_ready` is low. A request that is offered while `req_ready` is low is neither taken nor lost; the block takes it on the first cycle in which `req_ready` is high. No data is dropped at either edge.

Top module: `tiled_view_addr`

## Requirements
- R1: After reset `res_valid` is 0 and `req_ready` is 1. A request taken on a clock edge (`req_valid` and `req_ready` both high) appears on the outputs with `res_valid` high after that same edge, which is one cycle of latency. With `res_ready` held high, requests are taken on back-to-back cycles.
- R2: While `res_valid` is 1 and `res_ready` is 0, `req_ready` is 0 and every result output holds its value. A request offered meanwhile is taken once `res_ready` rises.
- R3: For an in-range request, address bits [31:29] equal the view code and bits [28:27] equal the format code. The format codes are 0 = 8-bit, 1 = 16-bit, 2 = 32-bit and 3 = page mode.
- R4: The format sets the dropped bits (xs, ys): 8-bit (0,0), 16-bit (0,1), 32-bit (1,1), page (6,6). The usable widths are xw = 14 − xs and yw = 13 − ys.
- R5: With view bit 2 clear, address bits [26:0] equal ((y << xw) + x) << (xs + ys).
- R6: With view bit 2 set, address bits [26:0] equal ((x << yw) + y) << (xs + ys).
- R7: View bit 0 replaces x by x XOR (2^xw − 1), and view bit 1 replaces y by y XOR (2^yw − 1). Both happen before the combination of R5 or R6.
- R8: If x > 2^xw − 1 or y > 2^yw − 1, then `res_coord_ok` is 0 and the address is 0. Otherwise `res_coord_ok` is 1.
- R9: The stride is 2^(13 + xs) when view bit 2 is set and 2^(14 + ys) otherwise.
- R10: The slot width is 2^(6 − xs) pixels and the slot height is 2^(6 − ys) pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request is taken this cycle |
| req_fmt | input | 2 | Pixel format code |
| req_view | input | 3 | View code: bit 0 mirrors x, bit 1 mirrors y, bit 2 transposes |
| req_x | input | 14 | Pixel x coordinate |
| req_y | input | 13 | Pixel y coordinate |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_coord_ok | output | 1 | Coordinate was inside the format's range |
| res_addr | output | 32 | Tiled view address |
| res_stride | output | 21 | Line stride in bytes of address space |
| res_slot_w | output | 7 | Slot width in pixels |
| res_slot_h | output | 7 | Slot height in pixels |

## Verification
The bench drives every format under the identity view with asymmetric coordinates. This separates the x field from the y field and shows how far each format shifts them. The same coordinates then go through each mirror bit alone, through both mirror bits together, and through the transposed views, so that a swapped mirror bit or an unswapped field shows up as a different address. Coordinates just inside and just outside each format's range exercise the range check. A stalled output with a changing pending request, followed by a back-to-back stream, shows whether the handshake holds, drops or duplicates a result.

// File: rtl/tva_pkg.sv
package tva_pkg;
  typedef enum logic [1:0] {
    TVA_FMT_8    = 2'd0,
    TVA_FMT_16   = 2'd1,
    TVA_FMT_32   = 2'd2,
    TVA_FMT_PAGE = 2'd3
  } tva_fmt_e;

  localparam int VIEW_XINV = 0;
  localparam int VIEW_YINV = 1;
  localparam int VIEW_SWAP = 2;
endpackage

// File: rtl/tva_geom.sv
module tva_geom #(
  parameter int CW_BITS = 14,
  parameter int CH_BITS = 13,
  parameter int SW_BITS = 6,
  parameter int SH_BITS = 6,
  localparam int SHW     = $clog2(SW_BITS + SH_BITS + 1),
  localparam int WW      = $clog2(CW_BITS + 1),
  localparam int SLW     = ((SW_BITS > SH_BITS) ? SW_BITS : SH_BITS) + 1,
  localparam int STR_MAX = ((CH_BITS + SW_BITS) > (CW_BITS + SH_BITS)) ?
                           (CH_BITS + SW_BITS) : (CW_BITS + SH_BITS),
  localparam int STRIDE_W = STR_MAX + 1
) (
  input  logic [1:0]          fmt,
  input  logic                swap,
  output logic [SHW-1:0]      xs,
  output logic [SHW-1:0]      ys,
  output logic [WW-1:0]       xw,
  output logic [WW-1:0]       yw,
  output logic [CW_BITS-1:0]  xmask,
  output logic [CH_BITS-1:0]  ymask,
  output logic [STRIDE_W-1:0] stride,
  output logic [SLW-1:0]      slot_w,
  output logic [SLW-1:0]      slot_h
);
  import tva_pkg::*;

  always_comb begin
    unique case (tva_fmt_e'(fmt))
      TVA_FMT_8:  begin xs = SHW'(0);       ys = SHW'(0);       end
      TVA_FMT_16: begin xs = SHW'(0);       ys = SHW'(1);       end
      TVA_FMT_32: begin xs = SHW'(1);       ys = SHW'(1);       end
      default:    begin xs = SHW'(SW_BITS); ys = SHW'(SH_BITS); end
    endcase
  end

  assign xw     = WW'(CW_BITS - int'(xs));
  assign yw     = WW'(CH_BITS - int'(ys));
  assign xmask  = CW_BITS'((64'd1 << xw) - 64'd1);
  assign ymask  = CH_BITS'((64'd1 << yw) - 64'd1);
  assign stride = swap ? (STRIDE_W'(1) << (CH_BITS + int'(xs)))
                       : (STRIDE_W'(1) << (CW_BITS + int'(ys)));
  assign slot_w = SLW'(1) << (SW_BITS - int'(xs));
  assign slot_h = SLW'(1) << (SH_BITS - int'(ys));
endmodule

// File: rtl/tva_map.sv
module tva_map #(
  parameter int CW_BITS = 14,
  parameter int CH_BITS = 13,
  parameter int SHW     = 4,
  parameter int WW      = 4,
  localparam int OFF_W  = CW_BITS + CH_BITS
) (
  input  logic [CW_BITS-1:0] x,
  input  logic [CH_BITS-1:0] y,
  input  logic [2:0]         view,
  input  logic [SHW-1:0]     xs,
  input  logic [SHW-1:0]     ys,
  input  logic [WW-1:0]      xw,
  input  logic [WW-1:0]      yw,
  input  logic [CW_BITS-1:0] xmask,
  input  logic [CH_BITS-1:0] ymask,
  output logic               in_range,
  output logic [OFF_W-1:0]   offset
);
  import tva_pkg::*;

  logic [CW_BITS-1:0] xm;
  logic [CH_BITS-1:0] ym;
  logic [OFF_W-1:0]   linear;
  logic [SHW:0]       align;

  assign in_range = (x <= xmask) && (y <= ymask);
  assign xm       = view[VIEW_XINV] ? (x ^ xmask) : x;
  assign ym       = view[VIEW_YINV] ? (y ^ ymask) : y;
  assign linear   = view[VIEW_SWAP] ? ((OFF_W'(xm) << yw) + OFF_W'(ym))
                                    : ((OFF_W'(ym) << xw) + OFF_W'(xm));
  assign align    = {1'b0, xs} + {1'b0, ys};
  assign offset   = in_range ? (linear << align) : '0;
endmodule

// File: rtl/tva_outreg.sv
module tva_outreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/tiled_view_addr.sv
module tiled_view_addr #(
  parameter int CW_BITS = 14,
  parameter int CH_BITS = 13,
  parameter int SW_BITS = 6,
  parameter int SH_BITS = 6,
  localparam int SHW     = $clog2(SW_BITS + SH_BITS + 1),
  localparam int WW      = $clog2(CW_BITS + 1),
  localparam int SLW     = ((SW_BITS > SH_BITS) ? SW_BITS : SH_BITS) + 1,
  localparam int STR_MAX = ((CH_BITS + SW_BITS) > (CW_BITS + SH_BITS)) ?
                           (CH_BITS + SW_BITS) : (CW_BITS + SH_BITS),
  localparam int STRIDE_W = STR_MAX + 1,
  localparam int OFF_W    = CW_BITS + CH_BITS,
  localparam int ADDR_W   = OFF_W + 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          req_fmt,
  input  logic [2:0]          req_view,
  input  logic [CW_BITS-1:0]  req_x,
  input  logic [CH_BITS-1:0]  req_y,
  output logic                res_valid,
  input  logic                res_ready,
  output logic                res_coord_ok,
  output logic [ADDR_W-1:0]   res_addr,
  output logic [STRIDE_W-1:0] res_stride,
  output logic [SLW-1:0]      res_slot_w,
  output logic [SLW-1:0]      res_slot_h
);
  import tva_pkg::*;

  localparam int PW = 1 + ADDR_W + STRIDE_W + 2 * SLW;

  logic [SHW-1:0]      xs, ys;
  logic [WW-1:0]       xw, yw;
  logic [CW_BITS-1:0]  xmask;
  logic [CH_BITS-1:0]  ymask;
  logic [STRIDE_W-1:0] stride;
  logic [SLW-1:0]      slot_w, slot_h;
  logic                in_range;
  logic [OFF_W-1:0]    offset;
  logic [ADDR_W-1:0]   addr;
  logic [PW-1:0]       pay_in, pay_out;

  tva_geom #(
    .CW_BITS(CW_BITS), .CH_BITS(CH_BITS), .SW_BITS(SW_BITS), .SH_BITS(SH_BITS)
  ) u_geom (
    .fmt(req_fmt), .swap(req_view[VIEW_SWAP]),
    .xs(xs), .ys(ys), .xw(xw), .yw(yw), .xmask(xmask), .ymask(ymask),
    .stride(stride), .slot_w(slot_w), .slot_h(slot_h)
  );

  tva_map #(
    .CW_BITS(CW_BITS), .CH_BITS(CH_BITS), .SHW(SHW), .WW(WW)
  ) u_map (
    .x(req_x), .y(req_y), .view(req_view),
    .xs(xs), .ys(ys), .xw(xw), .yw(yw), .xmask(xmask), .ymask(ymask),
    .in_range(in_range), .offset(offset)
  );

  assign addr   = in_range ? {req_view, req_fmt, offset} : '0;
  assign pay_in = {in_range, addr, stride, slot_w, slot_h};

  tva_outreg #(.W(PW)) u_reg (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready), .in_data(pay_in),
    .out_valid(res_valid), .out_ready(res_ready), .out_data(pay_out)
  );

  assign {res_coord_ok, res_addr, res_stride, res_slot_w, res_slot_h} = pay_out;
endmodule

// File: rtl/tva_checker.sv
module tva_checker #(
  parameter int CW_BITS  = 14,
  parameter int SW_BITS  = 6,
  parameter int ADDR_W   = 32,
  parameter int STRIDE_W = 21,
  parameter int SLW      = 7
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic [1:0]          req_fmt,
  input logic [2:0]          req_view,
  input logic [CW_BITS-1:0]  req_x,
  input logic                res_valid,
  input logic                res_ready,
  input logic                res_coord_ok,
  input logic [ADDR_W-1:0]   res_addr,
  input logic [STRIDE_W-1:0] res_stride,
  input logic [SLW-1:0]      res_slot_w,
  input logic [SLW-1:0]      res_slot_h
);
  assert_take_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> res_valid);

  assert_hold_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_addr) &&
                                   $stable(res_stride) && $stable(res_coord_ok)));

  assert_code_fields_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=>
      (!res_coord_ok || res_addr[ADDR_W-1:ADDR_W-5] == {$past(req_view), $past(req_fmt)}));

  assert_page_x_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_fmt == 2'd3 && (req_x >> (CW_BITS - SW_BITS)) != '0)
      |=> (!res_coord_ok && res_addr == '0));

  assert_stride_pow2_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($countones(res_stride) == 1));

  assert_slot_pow2_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($countones(res_slot_w) == 1 && $countones(res_slot_h) == 1));
endmodule

bind tiled_view_addr tva_checker #(
  .CW_BITS(CW_BITS), .SW_BITS(SW_BITS), .ADDR_W(ADDR_W),
  .STRIDE_W(STRIDE_W), .SLW(SLW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_fmt(req_fmt), .req_view(req_view), .req_x(req_x),
  .res_valid(res_valid), .res_ready(res_ready), .res_coord_ok(res_coord_ok),
  .res_addr(res_addr), .res_stride(res_stride),
  .res_slot_w(res_slot_w), .res_slot_h(res_slot_h)
);

// File: tb/tiled_view_addr_bench.sv
module tiled_view_addr_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_fmt = '0;
  logic [2:0]  req_view = '0;
  logic [13:0] req_x = '0;
  logic [12:0] req_y = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_coord_ok;
  logic [31:0] res_addr;
  logic [20:0] res_stride;
  logic [6:0]  res_slot_w, res_slot_h;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tiled_view_addr u_tiled_view_addr (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_fmt(req_fmt), .req_view(req_view), .req_x(req_x), .req_y(req_y),
    .res_valid(res_valid), .res_ready(res_ready), .res_coord_ok(res_coord_ok),
    .res_addr(res_addr), .res_stride(res_stride),
    .res_slot_w(res_slot_w), .res_slot_h(res_slot_h)
  );

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  task automatic check1(string req, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Expected result from the requirement formulas (R3..R10)
  task automatic expect_result(string req, logic [1:0] f, logic [2:0] v,
                               int x, int y);
    int xs, ys, xw, yw;
    longint xmk, ymk, xx, yy, t, off, addr, strd;
    bit ok;
    case (f)
      2'd0: begin xs = 0; ys = 0; end
      2'd1: begin xs = 0; ys = 1; end
      2'd2: begin xs = 1; ys = 1; end
      default: begin xs = 6; ys = 6; end
    endcase
    xw = 14 - xs; yw = 13 - ys;
    xmk = (64'd1 << xw) - 1; ymk = (64'd1 << yw) - 1;
    ok = (x <= xmk) && (y <= ymk);
    xx = v[0] ? (longint'(x) ^ xmk) : longint'(x);
    yy = v[1] ? (longint'(y) ^ ymk) : longint'(y);
    t = v[2] ? ((xx << yw) + yy) : ((yy << xw) + xx);
    off = t << (xs + ys);
    addr = ok ? ((longint'(v) << 29) | (longint'(f) << 27) | (off & 64'h7FF_FFFF)) : 0;
    strd = v[2] ? (64'd1 << (13 + xs)) : (64'd1 << (14 + ys));
    check1({req, " valid"}, res_valid, 1);
    check1({req, " coord_ok R8"}, res_coord_ok, ok);
    check1({req, " addr"}, res_addr, addr);
    check1({req, " stride R9"}, res_stride, strd);
    check1({req, " slot_w R10"}, res_slot_w, 64'd1 << (6 - xs));
    check1({req, " slot_h R10"}, res_slot_h, 64'd1 << (6 - ys));
  endtask

  task automatic drive(logic [1:0] f, logic [2:0] v, int x, int y);
    req_valid = 1'b1; req_fmt = f; req_view = v;
    req_x = 14'(x); req_y = 13'(y);
  endtask

  task automatic one(string req, logic [1:0] f, logic [2:0] v, int x, int y);
    @(negedge clk); drive(f, v, x, y);
    @(negedge clk); req_valid = 1'b0;
    expect_result(req, f, v, x, y);
  endtask

  task automatic t_reset();
    check1("R1 reset res_valid", res_valid, 0);
    check1("R1 reset req_ready", req_ready, 1);
  endtask

  task automatic t_plain();
    for (int f = 0; f < 4; f++) begin
      one("R3 R4 R5 plain", 2'(f), 3'd0, 37, 5);
      one("R5 plain", 2'(f), 3'd0, 200, 100);
    end
  endtask

  task automatic t_mirror();
    for (int v = 1; v < 4; v++) begin
      one("R7 mirror 8b", 2'd0, 3'(v), 1234, 567);
      one("R7 mirror 32b", 2'd2, 3'(v), 77, 3000);
    end
  endtask

  task automatic t_swap();
    for (int v = 4; v < 8; v++) begin
      one("R6 swap 16b", 2'd1, 3'(v), 900, 41);
      one("R6 swap page", 2'd3, 3'(v), 17, 99);
    end
  endtask

  task automatic t_range();
    one("R8 32b x max", 2'd2, 3'd0, 8191, 4095);
    one("R8 32b x over", 2'd2, 3'd0, 8192, 0);
    one("R8 16b y over", 2'd1, 3'd5, 10, 4096);
    one("R8 page x max", 2'd3, 3'd3, 255, 127);
    one("R8 page x over", 2'd3, 3'd0, 256, 0);
    one("R8 page y over", 2'd3, 3'd6, 0, 128);
    one("R8 8b corner", 2'd0, 3'd7, 16383, 8191);
  endtask

  task automatic t_stall();
    @(negedge clk); res_ready = 1'b0; drive(2'd1, 3'd2, 50, 60);
    @(negedge clk);
    check1("R2 stall req_ready", req_ready, 0);
    expect_result("R2 stalled A", 2'd1, 3'd2, 50, 60);
    drive(2'd2, 3'd6, 700, 800);
    @(negedge clk); @(negedge clk);
    check1("R2 still stalled req_ready", req_ready, 0);
    expect_result("R2 held A", 2'd1, 3'd2, 50, 60);
    res_ready = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    expect_result("R2 released B", 2'd2, 3'd6, 700, 800);
    @(negedge clk);
    check1("R2 drained", res_valid, 0);
  endtask

  task automatic t_stream();
    int xs[4] = '{3, 1000, 250, 4000};
    int ys[4] = '{9, 20, 120, 2000};
    @(negedge clk); drive(2'(0), 3'(1), xs[0], ys[0]);
    for (int i = 1; i < 4; i++) begin
      @(negedge clk);
      expect_result("R1 stream", 2'(i-1), 3'(i), xs[i-1], ys[i-1]);
      drive(2'(i), 3'(i+1), xs[i], ys[i]);
    end
    @(negedge clk); req_valid = 1'b0;
    expect_result("R1 stream last", 2'd3, 3'd4, xs[3], ys[3]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_plain();
    t_mirror();
    t_swap();
    t_range();
    t_stall();
    t_stream();
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
  end
endmodule